// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns an eight-bit parallel word into a serial bit stream. It runs on a fast system clock and treats its control pins as slow external signals. The load strobe, the shift clock, the shift inhibit and the serial input each pass through a chain of synchroniser flops. A small controller then watches the synchronised pins and decides, one system cycle at a time, whether the register copies the parallel word, shifts by one place or keeps its contents.

The shift clock and the inhibit act as one clock: they are ORed, and a rising edge of the OR shifts the register. A pulse on the shift clock therefore shifts while the inhibit is low. A pulse on the inhibit shifts in the same way while the shift clock is low. If either pin is held high, the register holds. A low load strobe wins over everything else, and the register keeps copying the parallel word for as long as the strobe stays low. Stage 0 takes the serial input and the last stage drives a true output and an inverted output, so several of these blocks can be chained into a longer register.

The controller has three states:
- `ST_LOAD`: the load strobe is low.
- `ST_ARMED`: the load strobe is high and the ORed clock is low, so the next rise shifts.
- `ST_HELD`: the load strobe is high and the ORed clock is high, so the register waits for it to fall.

The controller moves between these states as follows:
- Any state goes to `ST_LOAD` when the strobe is low.
- `ST_LOAD` goes to `ST_HELD` or `ST_ARMED` on release, depending on the ORed clock.
- `ST_ARMED` goes to `ST_HELD` on a rise. That transition is the only one that shifts.
- `ST_HELD` goes to `ST_ARMED` on a fall.

Top module: `piso_serializer`

## Requirements
- R1: While reset is asserted and after it is released with idle pins, every stage is 0, `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is low, all stages take `par_in`, and activity on `shift_clk`, `inhibit` and `ser_in` has no effect.
- R3: While `load_n` stays low, `ser_out` follows `par_in[7]` (the most significant input bit) with no clock edge needed. A change of `par_in` shows up within SYNC_DEPTH+2 system cycles.
- R4: With `load_n` high and `inhibit` low, a low-to-high edge of `shift_clk` shifts the register once. `ser_in` enters stage 0, stage n takes stage n-1, and the old stage 6 reaches stage 7.
- R5: With `load_n` high and `shift_clk` low, a low-to-high edge of `inhibit` shifts the register exactly as in R4.
- R6: With `load_n` high, while either `shift_clk` or `inhibit` stays high, edges on the other pin leave the register unchanged.
- R7: A fall of `inhibit` while `shift_clk` is high, and the later fall of `shift_clk`, cause no shift.
- R8: When `load_n` rises in the same synchronised sample as a rise of the ORed clock, that rise is ignored and the register keeps the loaded word.
- R9: `ser_out_n` is always the complement of `ser_out`, and both come from the last stage only.
- R10: When the `ser_out` of one block drives the `ser_in` of a second block on the same pins, the pair behaves as one 16-stage register, with the first block's bits following the second block's bits out of the second block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples all pins |
| sys_rst | input | 1 | Synchronous active-high reset |
| par_in | input | STAGES | Parallel word; bit STAGES-1 is the stage nearest the output |
| ser_in | input | 1 | Serial data entering stage 0 |
| load_n | input | 1 | Active-low parallel load strobe |
| shift_clk | input | 1 | Shift clock pin; rising edges shift |
| inhibit | input | 1 | Shift inhibit; high blocks `shift_clk`, and its rise acts as a clock |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, inverted |

## Verification
The bench loads every 8-bit word, checks the transparent output during load, and then shifts each word all the way out. A wrong shift direction or a lost serial bit would show up in the very first bit stream.

It shifts with the inhibit pin as well as the clock pin, to catch a design that honours only one of the two. It pulses one pin while the other is held high, and drops the inhibit while the clock is high. A design that decodes the two pins as separate edges instead of as an OR would shift in those cases.

The load strobe is released in the same cycle as a clock rise. A design without load recovery would lose the top loaded bit there. Two chained instances check that bits cross the boundary in order, which fails if a block samples its serial input after its upstream neighbour has already updated.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } ctl_state_t;

    // bit positions inside the synchronised pin vector
    localparam int PIN_SER  = 0;
    localparam int PIN_INH  = 1;
    localparam int PIN_CLK  = 2;
    localparam int PIN_LOAD = 3;
    localparam int PIN_COUNT = 4;

endpackage

// File: rtl/piso_pin_sync.sv
module piso_pin_sync #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] pin_s
);

    logic [WIDTH-1:0] chain [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= INIT;
                    else     chain[i] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= INIT;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign pin_s = chain[DEPTH-1];

endmodule

// File: rtl/piso_edge_ctl.sv
module piso_edge_ctl
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_s,
    input  logic clk_s,
    input  logic inh_s,
    output logic load_go,
    output logic shift_go
);

    ctl_state_t state, state_nx;
    logic       or_clk;

    assign or_clk = clk_s | inh_s;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HELD;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:  if (load_s) state_nx = or_clk ? ST_HELD : ST_ARMED;
            ST_ARMED: if (!load_s) state_nx = ST_LOAD;
                      else if (or_clk) state_nx = ST_HELD;
            ST_HELD:  if (!load_s) state_nx = ST_LOAD;
                      else if (!or_clk) state_nx = ST_ARMED;
            default:  state_nx = ST_HELD;
        endcase
    end

    always_comb begin
        load_go  = 1'b0;
        shift_go = 1'b0;
        unique case (state)
            ST_LOAD:  load_go = !load_s;
            ST_ARMED: begin
                load_go  = !load_s;
                shift_go = load_s && or_clk;
            end
            ST_HELD:  load_go = !load_s;
            default:  load_go = !load_s;
        endcase
    end

    // a shift only follows a sample in which the ORed clock was low
    assert_edge_needed_R6: assert property (@(posedge clk) disable iff (rst)
        shift_go |-> !($past(clk_s) || $past(inh_s)));

    // release of the load strobe cannot shift in that same sample
    assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
        (load_s && !$past(load_s)) |-> !shift_go);

endmodule

// File: rtl/piso_shift_core.sv
module piso_shift_core #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_go,
    input  logic              shift_go,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_bit,
    output logic [STAGES-1:0] stage
);

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_bit
            logic feed;
            if (i == 0) begin : g_head
                assign feed = ser_bit;
            end else begin : g_body
                assign feed = stage[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst)           stage[i] <= 1'b0;
                else if (load_go)  stage[i] <= par_in[i];
                else if (shift_go) stage[i] <= feed;
            end
        end
    endgenerate

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stage == '0));

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (stage == $past(par_in)));

    assert_shift_move_R4: assert property (@(posedge clk) disable iff (rst)
        (shift_go && !load_go) |=> (stage == {$past(stage[STAGES-2:0]), $past(ser_bit)}));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!shift_go && !load_go) |=> $stable(stage));

endmodule

// File: rtl/piso_serializer.sv
module piso_serializer
    import piso_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_in,
    input  logic              load_n,
    input  logic              shift_clk,
    input  logic              inhibit,
    output logic              ser_out,
    output logic              ser_out_n
);

    localparam int LAST = STAGES - 1;
    // idle pins: load released, both clock pins high (wait for a fall), serial 0
    localparam logic [PIN_COUNT-1:0] PIN_INIT = 4'b1110;

    logic [PIN_COUNT-1:0] pins, pins_s;
    logic                 load_go, shift_go;
    logic [STAGES-1:0]    stage;

    assign pins[PIN_SER]  = ser_in;
    assign pins[PIN_INH]  = inhibit;
    assign pins[PIN_CLK]  = shift_clk;
    assign pins[PIN_LOAD] = load_n;

    piso_pin_sync #(
        .WIDTH (PIN_COUNT),
        .DEPTH (SYNC_DEPTH),
        .INIT  (PIN_INIT)
    ) u_sync (
        .clk   (sys_clk),
        .rst   (sys_rst),
        .pin   (pins),
        .pin_s (pins_s)
    );

    piso_edge_ctl u_ctl (
        .clk      (sys_clk),
        .rst      (sys_rst),
        .load_s   (pins_s[PIN_LOAD]),
        .clk_s    (pins_s[PIN_CLK]),
        .inh_s    (pins_s[PIN_INH]),
        .load_go  (load_go),
        .shift_go (shift_go)
    );

    piso_shift_core #(
        .STAGES (STAGES)
    ) u_core (
        .clk      (sys_clk),
        .rst      (sys_rst),
        .load_go  (load_go),
        .shift_go (shift_go),
        .par_in   (par_in),
        .ser_bit  (pins_s[PIN_SER]),
        .stage    (stage)
    );

    assign ser_out   = stage[LAST];
    assign ser_out_n = ~stage[LAST];

    // load never coincides with a shift decision
    assert_load_wins_R2: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !pins_s[PIN_LOAD] |-> (load_go && !shift_go));

    // the output stage moves only on a load or a shift
    assert_out_quiet_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
        ($past(!load_go && !shift_go)) |-> (ser_out == $past(ser_out)));

endmodule

// File: tb/piso_serializer_test.sv
`timescale 1ns/1ps
module piso_serializer_test;

    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] par, par_b;
    logic       ser, load_n, clk_p, inh;
    logic       out_a, out_a_n, out_b, out_b_n;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  model;
    logic [15:0] chain;

    always #2.5 clk = ~clk;

    piso_serializer uut (
        .sys_clk(clk), .sys_rst(rst), .par_in(par), .ser_in(ser),
        .load_n(load_n), .shift_clk(clk_p), .inhibit(inh),
        .ser_out(out_a), .ser_out_n(out_a_n)
    );

    piso_serializer uut_b (
        .sys_clk(clk), .sys_rst(rst), .par_in(par_b), .ser_in(out_a),
        .load_n(load_n), .shift_clk(clk_p), .inhibit(inh),
        .ser_out(out_b), .ser_out_n(out_b_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_a(input string tag, input logic exp);
        check(tag, out_a, exp);
        check({tag, " R9 inverted"}, out_a_n, ~exp);
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        par = v; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
        model = v;
    endtask

    task automatic clk_pulse();
        clk_p = 1'b1; settle();
        model = {model[6:0], ser};
        chain = {chain[14:0], ser};
        clk_p = 1'b0; settle();
    endtask

    task automatic inh_pulse();
        inh = 1'b1; settle();
        model = {model[6:0], ser};
        inh = 1'b0; settle();
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 8; k++) begin
            check_a(tag, model[7]);
            ser = 1'b0;
            clk_pulse();
        end
        check_a(tag, model[7]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; par = '0; par_b = '0; ser = 1'b0;
        load_n = 1'b1; clk_p = 1'b0; inh = 1'b0;
        model = '0; chain = '0;
        repeat (3) @(negedge clk);
        check_a("R1 during reset", 1'b0);
        rst = 1'b0;
        settle();
        check_a("R1 after reset", 1'b0);

        // R2 / R3: transparent load over every word, clock activity ignored
        load_n = 1'b0;
        for (int v = 0; v < 256; v++) begin
            par = v[7:0];
            ser = ~v[0];
            settle();
            check_a("R3 transparent load", v[7]);
            clk_p = 1'b1; settle();
            inh = 1'b1; settle();
            clk_p = 1'b0; inh = 1'b0; settle();
            check_a("R2 load priority", v[7]);
        end
        load_n = 1'b1; settle();
        model = 8'hFF;
        check_a("R2 release", 1'b1);

        // R4: every word shifted out by the clock pin
        for (int v = 0; v < 256; v++) begin
            do_load(v[7:0]);
            for (int k = 0; k < 8; k++) begin
                check_a("R4 clock shift", model[7]);
                ser = ~v[k];
                clk_pulse();
            end
            check_a("R4 serial input reached end", model[7]);
        end

        // R5: shifting by the inhibit pin
        for (int v = 0; v < 256; v += 17) begin
            do_load(v[7:0]);
            for (int k = 0; k < 8; k++) begin
                check_a("R5 inhibit shift", model[7]);
                ser = v[k];
                inh_pulse();
            end
            check_a("R5 serial input reached end", model[7]);
        end

        // R6: one pin held high blocks the other
        do_load(8'hA5);
        ser = 1'b1;
        clk_p = 1'b1; settle();
        model = {model[6:0], ser};
        for (int k = 0; k < 3; k++) begin
            inh = 1'b1; settle(); inh = 1'b0; settle();
        end
        check_a("R6 clock held high", model[7]);
        clk_p = 1'b0; settle();
        ser = 1'b0;
        inh = 1'b1; settle();
        model = {model[6:0], ser};
        for (int k = 0; k < 3; k++) begin
            clk_p = 1'b1; settle(); clk_p = 1'b0; settle();
        end
        inh = 1'b0; settle();
        drain("R6 hold contents");

        // R7: inhibit falls while clock high
        do_load(8'h3C);
        ser = 1'b1;
        clk_p = 1'b1; settle();
        model = {model[6:0], ser};
        inh = 1'b1; settle();
        inh = 1'b0; settle();
        clk_p = 1'b0; settle();
        drain("R7 no shift on inhibit fall");

        // R8: load release together with a clock rise
        par = 8'hC3; ser = 1'b0;
        load_n = 1'b0; settle();
        load_n = 1'b1; clk_p = 1'b1; settle();
        clk_p = 1'b0; settle();
        model = 8'hC3;
        drain("R8 recovery clock pin");
        par = 8'h81; ser = 1'b0;
        load_n = 1'b0; settle();
        load_n = 1'b1; inh = 1'b1; settle();
        inh = 1'b0; settle();
        model = 8'h81;
        drain("R8 recovery inhibit pin");

        // R10: two blocks chained
        for (int p = 0; p < 4; p++) begin
            par   = 8'h5A ^ (8'(p) * 8'h33);
            par_b = 8'hE1 + 8'(p) * 8'h29;
            load_n = 1'b0; settle(); load_n = 1'b1; settle();
            chain = {par_b, par};
            model = par;
            for (int k = 0; k < 16; k++) begin
                check("R10 cascade output", out_b, chain[15]);
                check("R10 cascade inverted", out_b_n, ~chain[15]);
                ser = k[0] ^ k[1] ^ p[0];
                clk_pulse();
            end
            check("R10 cascade tail", out_b, chain[15]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule